// File: doc/BRIEF.md
# Parameterized ALU with HI/LO Registers

This block is a single-clock arithmetic and logic unit with a configurable data width (8 bits by default). It takes two operands and a 5-bit operation code. It returns a result of the same width and four status flags: zero, carry, signed overflow and error. Add, subtract, the six bitwise operations, the three unsigned comparisons and the two rotates are purely combinational.

Multiply and divide also produce a second value. Both values go into a pair of internal registers, HI and LO, at the next rising clock edge. Two move operations read those registers back onto the result bus. A surrounding datapath can therefore start a wide operation in one cycle and fetch both halves in later cycles. Only HI and LO hold state. A synchronous active-high reset clears both.

Top module: `alu_hilo`

## Requirements
- R1: Opcode 0 (add) gives result = (a + b) mod 2^W. Carry is the unsigned carry-out. Overflow is set when both operands have the same sign bit and the result's sign bit differs.
- R2: Opcode 1 (subtract) gives result = (a - b) mod 2^W. Carry is set when a < b unsigned (borrow). Overflow is set when the operand signs differ and the result's sign differs from a.
- R3: Opcodes 4..9 give, in this order, a AND b, a OR b, a XOR b, NOT(a AND b), NOT(a OR b) and NOT(a XOR b).
- R4: Opcodes 10 (equal), 11 (a > b) and 12 (a < b) compare unsigned. Each returns 1 or 0 in bit 0, with all other bits 0.
- R5: Opcode 13 rotates a left and opcode 14 rotates a right, by (b mod W) positions.
- R6: Opcode 2 (multiply) shows the low half of the 2W-bit product a*b on the result. At the next rising edge, HI takes the upper half and LO takes the lower half.
- R7: Opcode 3 (divide) with b != 0 shows the unsigned quotient on the result. At the next rising edge, LO takes the quotient and HI takes the remainder.
- R8: Divide with b = 0 sets error, drives a zero result and leaves HI and LO unchanged.
- R9: Opcode 15 places HI on the result, and opcode 16 places LO on the result.
- R10: Zero is 1 exactly when the result is all zeros, for every opcode.
- R11: Carry and overflow are 0 for every opcode other than 0 and 1.
- R12: Opcodes 17..31 set error, drive a zero result and leave HI and LO unchanged. Error is 0 for opcodes 0..16 except divide by zero.
- R13: With rst high at a rising edge, HI and LO become 0, even when a multiply is applied. Otherwise they change only on multiply or on divide by a nonzero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; HI/LO update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of HI and LO |
| op | input | 5 | Operation code |
| a | input | W | First operand |
| b | input | W | Second operand (divisor, rotate amount) |
| result | output | W | Combinational result |
| zero | output | 1 | Result is all zeros |
| carry | output | 1 | Carry-out on add, borrow on subtract |
| ovf | output | 1 | Two's-complement overflow on add and subtract |
| err | output | 1 | Divide by zero or unknown opcode |

## Verification
HI and LO are the only state, so a wrong internal state shows up only through opcodes 15 and 16, one cycle after the operation that wrote it. The bench reads both registers back right after every multiply and divide. It also reads them after operations that must not write them: divide by zero, unknown opcodes, and a multiply held under reset. A stray or missing update is therefore visible within two cycles. Combinational paths show errors in the same cycle, and the bench samples them shortly after driving the inputs.

// File: rtl/alu_hilo.sv
module alu_hilo #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         carry,
  output logic         ovf,
  output logic         err
);
  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_SUB  = 5'd1;
  localparam logic [4:0] OP_MUL  = 5'd2;
  localparam logic [4:0] OP_DIV  = 5'd3;
  localparam logic [4:0] OP_AND  = 5'd4;
  localparam logic [4:0] OP_OR   = 5'd5;
  localparam logic [4:0] OP_XOR  = 5'd6;
  localparam logic [4:0] OP_NAND = 5'd7;
  localparam logic [4:0] OP_NOR  = 5'd8;
  localparam logic [4:0] OP_XNOR = 5'd9;
  localparam logic [4:0] OP_EQ   = 5'd10;
  localparam logic [4:0] OP_GT   = 5'd11;
  localparam logic [4:0] OP_LT   = 5'd12;
  localparam logic [4:0] OP_ROL  = 5'd13;
  localparam logic [4:0] OP_ROR  = 5'd14;
  localparam logic [4:0] OP_MFHI = 5'd15;
  localparam logic [4:0] OP_MFLO = 5'd16;
  localparam int DW = 2 * W;

  logic [W-1:0]  hi, lo;
  logic [W:0]    sum, diff;
  logic [DW-1:0] prod, rol_w, ror_w;
  logic [W-1:0]  quo, rem, amt;
  logic          divz;

  assign sum   = {1'b0, a} + {1'b0, b};
  assign diff  = {1'b0, a} - {1'b0, b};
  assign prod  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign divz  = (b == '0);
  assign quo   = divz ? '0 : a / b;
  assign rem   = divz ? '0 : a % b;
  assign amt   = W'(b % W);
  assign rol_w = {a, a} << amt;
  assign ror_w = {a, a} >> amt;

  always_comb begin
    result = '0;
    carry  = 1'b0;
    ovf    = 1'b0;
    err    = 1'b0;
    case (op)
      OP_ADD: begin
        result = sum[W-1:0];
        carry  = sum[W];
        ovf    = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      OP_SUB: begin
        result = diff[W-1:0];
        carry  = diff[W];
        ovf    = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      end
      OP_MUL:  result = prod[W-1:0];
      OP_DIV: begin
        result = quo;
        err    = divz;
      end
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_NAND: result = ~(a & b);
      OP_NOR:  result = ~(a | b);
      OP_XNOR: result = ~(a ^ b);
      OP_EQ:   result = W'(a == b);
      OP_GT:   result = W'(a > b);
      OP_LT:   result = W'(a < b);
      OP_ROL:  result = rol_w[DW-1:W];
      OP_ROR:  result = ror_w[W-1:0];
      OP_MFHI: result = hi;
      OP_MFLO: result = lo;
      default: err = 1'b1;
    endcase
  end

  assign zero = (result == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (op == OP_MUL) begin
      hi <= prod[DW-1:W];
      lo <= prod[W-1:0];
    end else if (op == OP_DIV && !divz) begin
      hi <= rem;
      lo <= quo;
    end
  end

  assert_mult_R6: assert property (@(posedge clk) disable iff (rst)
    op == OP_MUL |=> {hi, lo} == ({{W{1'b0}}, $past(a)} * {{W{1'b0}}, $past(b)}));

  assert_hilo_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !(op == OP_MUL || (op == OP_DIV && b != '0)) |=> $stable(hi) && $stable(lo));

  assert_reset_clear_R13: assert property (@(posedge clk)
    rst |=> hi == '0 && lo == '0);

  assert_divzero_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIV && b == '0) |-> err && result == '0);

  assert_cmp_bit0_R4: assert property (@(posedge clk) disable iff (rst)
    (op >= OP_EQ && op <= OP_LT) |-> result[W-1:1] == '0);

  assert_flags_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !(op == OP_ADD || op == OP_SUB) |-> !carry && !ovf);

  assert_bad_op_R12: assert property (@(posedge clk) disable iff (rst)
    op > OP_MFLO |-> err && result == '0);

  assert_move_R9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MFHI |-> result == hi) and (op == OP_MFLO |-> result == lo));
endmodule

// File: tb/alu_hilo_tb.sv
module alu_hilo_tb;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] result;
  logic zero, carry, ovf, err;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  alu_hilo #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b),
    .result(result), .zero(zero), .carry(carry), .ovf(ovf), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [4:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    op = 5'd2; a = 8'd3; b = 8'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; op = 5'd15; #1;
    chk("R13 reset HI", result, 8'h00);
    chk("R10 zero after reset", zero, 1);
    drive(5'd16, 0, 0);
    chk("R13 reset LO", result, 8'h00);
  endtask

  task automatic t_add;
    drive(5'd0, 200, 100);
    chk("R1 add sum", result, 8'd44);
    chk("R1 add carry", carry, 1);
    chk("R1 add ovf", ovf, 0);
    drive(5'd0, 100, 50);
    chk("R1 add sum2", result, 8'd150);
    chk("R1 add ovf2", ovf, 1);
    chk("R1 add carry2", carry, 0);
    drive(5'd0, 0, 0);
    chk("R10 add zero", zero, 1);
  endtask

  task automatic t_sub;
    drive(5'd1, 5, 10);
    chk("R2 sub diff", result, 8'd251);
    chk("R2 sub borrow", carry, 1);
    chk("R2 sub ovf", ovf, 0);
    drive(5'd1, 8'h80, 1);
    chk("R2 sub diff2", result, 8'h7F);
    chk("R2 sub ovf2", ovf, 1);
    chk("R2 sub borrow2", carry, 0);
    drive(5'd1, 7, 7);
    chk("R10 sub zero", zero, 1);
  endtask

  task automatic t_logic;
    logic [W-1:0] exp [6];
    exp[0] = 8'h48; exp[1] = 8'hDE; exp[2] = 8'h96;
    exp[3] = 8'hB7; exp[4] = 8'h21; exp[5] = 8'h69;
    for (int i = 0; i < 6; i++) begin
      drive(5'(4 + i), 8'hCA, 8'h5C);
      chk("R3 logic op", result, exp[i]);
      chk("R11 logic flags", {carry, ovf}, 0);
      chk("R12 logic no err", err, 0);
    end
  endtask

  task automatic t_compare;
    drive(5'd10, 8'h80, 8'h7F);
    chk("R4 eq false", result, 0);
    chk("R10 eq zero", zero, 1);
    drive(5'd11, 8'h80, 8'h7F);
    chk("R4 gt unsigned", result, 1);
    drive(5'd12, 8'h80, 8'h7F);
    chk("R4 lt unsigned", result, 0);
    drive(5'd10, 8'h33, 8'h33);
    chk("R4 eq true", result, 1);
    drive(5'd12, 8'h33, 8'h33);
    chk("R4 lt equal", result, 0);
  endtask

  task automatic t_rotate;
    drive(5'd13, 8'h81, 1);
    chk("R5 rol 1", result, 8'h03);
    drive(5'd14, 8'h81, 1);
    chk("R5 ror 1", result, 8'hC0);
    drive(5'd13, 8'h81, 9);
    chk("R5 rol mod W", result, 8'h03);
    drive(5'd14, 8'h81, 8);
    chk("R5 ror by W", result, 8'h81);
    drive(5'd13, 8'h96, 4);
    chk("R5 rol 4", result, 8'h69);
  endtask

  task automatic t_mult;
    drive(5'd2, 200, 150);
    chk("R6 mul low", result, 8'h30);
    chk("R11 mul flags", {carry, ovf}, 0);
    drive(5'd15, 0, 0);
    chk("R9 mfhi after mul", result, 8'h75);
    drive(5'd16, 0, 0);
    chk("R9 mflo after mul", result, 8'h30);
    drive(5'd2, 255, 255);
    drive(5'd0, 1, 1);
    drive(5'd15, 0, 0);
    chk("R6 mul hi max", result, 8'hFE);
    drive(5'd16, 0, 0);
    chk("R6 mul lo max", result, 8'h01);
  endtask

  task automatic t_div;
    drive(5'd3, 200, 7);
    chk("R7 div quotient", result, 8'd28);
    chk("R12 div no err", err, 0);
    drive(5'd15, 0, 0);
    chk("R7 div rem HI", result, 8'd4);
    drive(5'd16, 0, 0);
    chk("R7 div quo LO", result, 8'd28);
  endtask

  task automatic t_divzero;
    drive(5'd2, 16, 17);
    drive(5'd3, 99, 0);
    chk("R8 div0 err", err, 1);
    chk("R8 div0 result", result, 0);
    drive(5'd15, 0, 0);
    chk("R8 div0 HI kept", result, 8'h01);
    drive(5'd16, 0, 0);
    chk("R8 div0 LO kept", result, 8'h10);
  endtask

  task automatic t_invalid;
    drive(5'd2, 3, 5);
    drive(5'd17, 8'hFF, 8'hFF);
    chk("R12 op17 err", err, 1);
    chk("R12 op17 result", result, 0);
    chk("R11 op17 flags", {carry, ovf}, 0);
    drive(5'd31, 8'h12, 8'h34);
    chk("R12 op31 err", err, 1);
    drive(5'd15, 0, 0);
    chk("R12 HI kept", result, 8'h00);
    chk("R10 mfhi zero", zero, 1);
    drive(5'd16, 0, 0);
    chk("R12 LO kept", result, 8'h0F);
    chk("R10 mflo nonzero", zero, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_compare();
    t_rotate();
    t_mult();
    t_div();
    t_divzero();
    t_invalid();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule